// File: doc/BRIEF.md
# CRC-Error Frame Alignment Loss Monitor

This block sits beside a T1/E1 framer and watches the outcome of each CRC check the framer makes. Each check shows up as a one-cycle strobe together with a fail flag. The block decides when CRC failures have become excessive. At that point it emits a one-cycle loss-of-alignment pulse, which the frame search logic uses to start hunting for alignment again.

The block offers two criteria. The first is a sliding window: alignment is lost once 32 of the most recent 33 checks have failed. The second is a per-second threshold: alignment is lost once more than 320 CRC errors arrive between two one-second ticks. The CRC criterion applies only to extended-superframe mode and to the E1 CRC-4 multiframe mode. In extended-superframe mode one option bit chooses between the two criteria. In CRC-4 mode the window criterion is always used. A second option bit turns CRC-driven loss of alignment off completely.

After it raises the pulse, the block clears all of its history and stays quiet until the framer reports that it has realigned.

Top module: `crc_lfa_monitor`

## Requirements
- R1: After reset, `lfa_o` is 0, `err_cnt_o` is 0, and the block is armed.
- R2: With `mode_i` = 2'b01 (extended superframe), `opt_i[0]` = 0 and `opt_i[1]` = 0, `lfa_o` pulses in the cycle after the strobe that brings the number of failures among the last 33 checks to 32.
- R3: In window mode, `err_cnt_o` equals the number of failed checks among the last 33 strobes. A failure that ages past 33 strobes no longer counts.
- R4: With `mode_i` = 2'b10 (CRC-4 multiframe), the window criterion is used whatever the value of `opt_i[1]`.
- R5: With `mode_i` = 2'b01, `opt_i[0]` = 0 and `opt_i[1]` = 1, `err_cnt_o` counts failed checks since the last `sec_tick_i`. `lfa_o` pulses in the cycle after the 321st failure. A tick clears the count, and a failure in the same cycle as a tick counts as the first failure of the new second. The count never exceeds 321.
- R6: While `opt_i[0]` = 1, `lfa_o` stays 0 and `err_cnt_o` is held at 0.
- R7: With `mode_i` = 2'b00 or 2'b11, `lfa_o` stays 0 and `err_cnt_o` is held at 0.
- R8: `opt_i[7:2]` have no effect on any output.
- R9: After a pulse, history and counters are 0, and further strobes neither raise `lfa_o` nor change `err_cnt_o` until `realign_i` is seen.
- R10: `realign_i` re-arms the block and clears history and counters in the same cycle. It takes priority over any strobe in that cycle.
- R11: `lfa_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| crc_strobe_i | input | 1 | One CRC check completed this cycle |
| crc_fail_i | input | 1 | The check flagged by the strobe failed |
| sec_tick_i | input | 1 | One-second timing tick |
| mode_i | input | 2 | 01 extended superframe, 10 CRC-4 multiframe, others no CRC criterion |
| opt_i | input | 8 | Bit 0 inhibits CRC loss, bit 1 selects the per-second criterion, bits 7:2 reserved |
| realign_i | input | 1 | Framer has regained alignment; re-arm |
| lfa_o | output | 1 | One-cycle loss-of-alignment request |
| err_cnt_o | output | 9 | Active criterion's error count |

## Verification
The bench builds the block with its default parameters: a 33-check window, a limit of 32 failures and a per-second limit of 320. With these values a burst of 32 back-to-back failures trips the window, and 321 failures inside one second trip the threshold. Both fit easily in a short run, so the exact real limits are exercised rather than scaled-down ones. Random strobe and fail patterns, mixed with ticks, realigns and changes of mode and option, check the sliding count, the way failures age out, and the quiet period after a pulse.

// File: rtl/crc_lfa_pkg.sv
package crc_lfa_pkg;

    typedef enum logic [1:0] {
        MODE_NONE = 2'b00,
        MODE_ESF  = 2'b01,
        MODE_CRC4 = 2'b10,
        MODE_RSVD = 2'b11
    } frm_mode_e;

    typedef struct packed {
        logic armed;
        logic lfa;
    } ctl_state_t;

endpackage

// File: rtl/crc_lfa_window.sv
module crc_lfa_window #(
    parameter int WIN_LEN      = 33,
    parameter int WIN_FAIL_LIM = 32,
    localparam int CW          = $clog2(WIN_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          flush_i,
    input  logic          step_i,
    input  logic          fail_i,
    output logic          hit_o,
    output logic [CW-1:0] cnt_o
);

    typedef struct packed {
        logic [WIN_LEN-1:0] hist;
        logic [CW-1:0]      cnt;
    } win_st_t;

    win_st_t win_q, win_d;
    win_st_t shifted;

    // Shifted view and threshold test, kept apart from the clear path.
    always_comb begin
        shifted = win_q;
        if (step_i) begin
            shifted.hist = {win_q.hist[WIN_LEN-2:0], fail_i};
            shifted.cnt  = win_q.cnt + CW'(fail_i) - CW'(win_q.hist[WIN_LEN-1]);
        end
        hit_o = step_i && !clr_i && (shifted.cnt >= CW'(WIN_FAIL_LIM));
    end

    always_comb begin
        win_d = shifted;
        if (clr_i || flush_i) begin
            win_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assign cnt_o = win_q.cnt;

    p_cnt_tracks_hist_r3: assert property (@(posedge clk) disable iff (!rst_n)
        32'(win_q.cnt) == $countones(win_q.hist));

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        win_q.cnt <= CW'(WIN_LEN));

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (win_q.cnt == '0) && (win_q.hist == '0));

endmodule

// File: rtl/crc_lfa_sec_counter.sv
module crc_lfa_sec_counter #(
    parameter int SEC_LIM = 320,
    localparam int SW     = $clog2(SEC_LIM + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          flush_i,
    input  logic          tick_i,
    input  logic          step_i,
    input  logic          fail_i,
    output logic          hit_o,
    output logic [SW-1:0] cnt_o
);

    logic [SW-1:0] cnt_q, cnt_d;
    logic [SW-1:0] nxt;
    logic          inc;

    // Tick opens a new second; a same-cycle error lands in the new second.
    always_comb begin
        nxt = tick_i ? '0 : cnt_q;
        inc = step_i && fail_i && (nxt <= SW'(SEC_LIM));
        if (inc) begin
            nxt = nxt + SW'(1);
        end
        hit_o = inc && !clr_i && (nxt == SW'(SEC_LIM + 1));
    end

    always_comb begin
        cnt_d = nxt;
        if (clr_i || flush_i) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= SW'(SEC_LIM + 1));

    p_tick_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !(step_i && fail_i)) |=> (cnt_q == '0));

    p_step_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_i && !flush_i) |=> (cnt_q >= $past(cnt_q)) && (cnt_q - $past(cnt_q) <= SW'(1)));

endmodule

// File: rtl/crc_lfa_monitor.sv
module crc_lfa_monitor
    import crc_lfa_pkg::*;
#(
    parameter int WIN_LEN      = 33,
    parameter int WIN_FAIL_LIM = 32,
    parameter int SEC_LIM      = 320,
    localparam int CW          = $clog2(WIN_LEN + 1),
    localparam int SW          = $clog2(SEC_LIM + 2),
    localparam int ERR_W       = (CW > SW) ? CW : SW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             crc_strobe_i,
    input  logic             crc_fail_i,
    input  logic             sec_tick_i,
    input  logic [1:0]       mode_i,
    input  logic [7:0]       opt_i,
    input  logic             realign_i,
    output logic             lfa_o,
    output logic [ERR_W-1:0] err_cnt_o
);

    frm_mode_e  mode;
    ctl_state_t ctl_q, ctl_d;
    logic       crc_mode, use_sec, active, sub_clr, decl;
    logic       win_hit, sec_hit;
    logic [CW-1:0] win_cnt;
    logic [SW-1:0] sec_cnt;
    logic       unused_rsvd;

    assign mode        = frm_mode_e'(mode_i);
    assign unused_rsvd = ^opt_i[7:2];

    always_comb begin
        crc_mode = (mode == MODE_ESF) || (mode == MODE_CRC4);
        use_sec  = (mode == MODE_ESF) && opt_i[1];
        active   = ctl_q.armed && !opt_i[0] && crc_mode;
        sub_clr  = realign_i || !active;
        decl     = active && !realign_i && (use_sec ? sec_hit : win_hit);

        ctl_d     = ctl_q;
        ctl_d.lfa = decl;
        if (realign_i) begin
            ctl_d.armed = 1'b1;
        end else if (decl) begin
            ctl_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{armed: 1'b1, lfa: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    crc_lfa_window #(
        .WIN_LEN      (WIN_LEN),
        .WIN_FAIL_LIM (WIN_FAIL_LIM)
    ) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (sub_clr),
        .flush_i (decl),
        .step_i  (crc_strobe_i),
        .fail_i  (crc_fail_i),
        .hit_o   (win_hit),
        .cnt_o   (win_cnt)
    );

    crc_lfa_sec_counter #(
        .SEC_LIM (SEC_LIM)
    ) u_sec (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (sub_clr),
        .flush_i (decl),
        .tick_i  (sec_tick_i),
        .step_i  (crc_strobe_i),
        .fail_i  (crc_fail_i),
        .hit_o   (sec_hit),
        .cnt_o   (sec_cnt)
    );

    assign lfa_o     = ctl_q.lfa;
    assign err_cnt_o = use_sec ? ERR_W'(sec_cnt) : ERR_W'(win_cnt);

    p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lfa_o |=> !lfa_o);

    p_disarm_after_lfa_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lfa_o |-> !ctl_q.armed);

    p_quiet_disarmed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.armed |=> !lfa_o);

    p_inhibit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        opt_i[0] |=> !lfa_o);

    p_mode_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !crc_mode |=> !lfa_o);

    p_realign_r10: assert property (@(posedge clk) disable iff (!rst_n)
        realign_i |=> (ctl_q.armed && !lfa_o && win_cnt == '0 && sec_cnt == '0));

endmodule

// File: tb/crc_lfa_monitor_tb.sv
module crc_lfa_monitor_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe = 1'b0, fail = 1'b0, tick = 1'b0, realign = 1'b0;
    logic [1:0] mode = 2'b01;
    logic [7:0] opt = 8'h00;
    logic       lfa_o;
    logic [8:0] err_cnt_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model, built from the requirements.
    bit [32:0] m_hist;
    int        m_wcnt, m_sec;
    bit        m_armed, m_lfa;

    always #5 clk = ~clk;

    crc_lfa_monitor u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .crc_strobe_i (strobe),
        .crc_fail_i   (fail),
        .sec_tick_i   (tick),
        .mode_i       (mode),
        .opt_i        (opt),
        .realign_i    (realign),
        .lfa_o        (lfa_o),
        .err_cnt_o    (err_cnt_o)
    );

    function automatic int exp_cnt();
        return (mode == 2'b01 && opt[1]) ? m_sec : m_wcnt;
    endfunction

    task automatic m_clear();
        m_hist = '0; m_wcnt = 0; m_sec = 0;
    endtask

    task automatic m_step(bit s, bit f, bit t, bit r);
        bit en, usec, inc, old, decl;
        en   = m_armed && !opt[0] && (mode == 2'b01 || mode == 2'b10);
        usec = (mode == 2'b01) && opt[1];
        m_lfa = 0;
        if (r) begin
            m_armed = 1; m_clear();
        end else if (!en) begin
            m_clear();
        end else begin
            if (t) m_sec = 0;
            inc = s && f && (m_sec < 321);
            if (inc) m_sec++;
            if (s) begin
                old = m_hist[32];
                m_hist = {m_hist[31:0], f};
                m_wcnt = m_wcnt + int'(f) - int'(old);
            end
            decl = usec ? (inc && m_sec == 321) : (s && m_wcnt >= 32);
            if (decl) begin
                m_lfa = 1; m_armed = 0; m_clear();
            end
        end
    endtask

    task automatic check(string tag);
        int e;
        e = exp_cnt();
        checks++;
        if (lfa_o !== m_lfa || err_cnt_o !== 9'(e)) begin
            errors++;
            $display("FAIL %s: lfa=%0b exp %0b, err_cnt=%0d exp %0d",
                     tag, lfa_o, m_lfa, err_cnt_o, e);
        end
    endtask

    task automatic cyc(bit s, bit f, bit t, bit r, string tag);
        @(negedge clk);
        strobe = s; fail = f; tick = t; realign = r;
        m_step(s, f, t, r);
        @(posedge clk);
        #1;
        check(tag);
    endtask

    task automatic rand_run(int n, int fail_pct, string tag);
        for (int i = 0; i < n; i++) begin
            bit s, f, t, r;
            s = ($urandom % 100) < 70;
            f = ($urandom % 100) < fail_pct;
            t = ($urandom % 100) < 2;
            r = ($urandom % 100) < 3;
            cyc(s, f, t, r, tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, exp done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_armed = 1; m_lfa = 0; m_clear();
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 after release");

        // R2: 31 failures, one pass, then failures until 32 of last 33 fail.
        mode = 2'b01; opt = 8'h00;
        for (int i = 0; i < 31; i++) cyc(1, 1, 0, 0, "R2 fill");
        cyc(1, 0, 0, 0, "R2 pass");
        cyc(1, 1, 0, 0, "R2 32nd fail");
        if (lfa_o !== 1'b1) begin
            errors++;
            $display("FAIL R2: lfa=%0b exp 1", lfa_o);
        end
        checks++;
        cyc(0, 0, 0, 0, "R11 pulse ends");

        // R9: quiet while disarmed.
        for (int i = 0; i < 40; i++) cyc(1, 1, 0, 0, "R9 disarmed");
        cyc(0, 0, 0, 1, "R10 realign");
        cyc(1, 1, 0, 1, "R10 realign beats strobe");

        // R3: failures age out of the window.
        for (int i = 0; i < 10; i++) cyc(1, 1, 0, 0, "R3 load");
        for (int i = 0; i < 40; i++) cyc(1, 0, 0, 0, "R3 age out");
        rand_run(400, 60, "R3 random");

        // R4: CRC-4 mode ignores the criterion-select bit.
        cyc(0, 0, 0, 1, "R10 rearm");
        mode = 2'b10; opt = 8'h02;
        for (int i = 0; i < 33; i++) cyc(1, 1, 0, 0, "R4 window");
        rand_run(300, 85, "R4 random");

        // R5: per-second criterion with tick clear.
        cyc(0, 0, 0, 1, "R10 rearm");
        mode = 2'b01; opt = 8'h02;
        for (int i = 0; i < 300; i++) cyc(1, 1, 0, 0, "R5 count");
        cyc(1, 1, 1, 0, "R5 tick with error");
        for (int i = 0; i < 320; i++) cyc(1, 1, 0, 0, "R5 threshold");
        rand_run(2000, 95, "R5 random");

        // R6: inhibit.
        cyc(0, 0, 0, 1, "R10 rearm");
        opt = 8'h01;
        for (int i = 0; i < 60; i++) cyc(1, 1, 0, 0, "R6 inhibit");
        opt = 8'h03;
        rand_run(200, 90, "R6 random");

        // R7: modes without a CRC criterion.
        opt = 8'h00; mode = 2'b00;
        for (int i = 0; i < 40; i++) cyc(1, 1, 0, 0, "R7 none");
        mode = 2'b11;
        rand_run(100, 90, "R7 reserved");

        // R8: reserved option bits.
        mode = 2'b01; opt = 8'hFC;
        cyc(0, 0, 0, 1, "R10 rearm");
        for (int i = 0; i < 33; i++) cyc(1, 1, 0, 0, "R8 reserved set");
        for (int i = 0; i < 20; i++) begin
            opt = 8'(($urandom & 32'hFC) | (i % 2 == 0 ? 0 : 2));
            mode = 2'($urandom % 4);
            rand_run(150, 80, "R8 R11 random mix");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule